// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter behind a small register file of four 32-bit words, selected by a 2-bit word index. Its configuration is guarded. Software first writes a two-word unlock key into the count register, which opens a short configuration period. During that period software may load a new limit and window. A write to the control word then commits the configuration, after which the period closes.

A second two-word key, written to the same register, restarts the count. If the count gets past the limit, the block raises a sticky timeout flag and pulses a reset request for one cycle. With a nonzero window, a restart that arrives while the count is still below the window is treated as a violation and gets the same response. The count advances on every clock cycle, or only on cycles where the slow tick-enable input is high, depending on the source field.

The key detector in each sequence has two states. IDLE goes to ARMED on the first key word. ARMED goes back to IDLE on any write, and raises a hit pulse if that write is the second key word to the count register. The lock controller has three states:
- SHUT goes to OPEN on an unlock hit.
- OPEN goes to SHUT on a control write that keeps updates permitted. It goes to FROZEN on a control write that forbids them. It goes to SHUT when the open period expires.
- FROZEN is left only by reset.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the control word reads 0x20 (only the update-permit bit 5 set). The count and window read 0, the limit reads LIMIT_RST, and irq and rst_req are low.
- R2: Unlock opens only when 0x0000C520 and then 0x0000D928 are written to word 1, with no other write between them. Control bit 11 then reads 1 and stays 1 while the period is open.
- R3: While the block is not open, writes to the limit (word 2) and window (word 3) are ignored. Control writes change nothing except the flag clear.
- R4: A control write (word 0) while open commits three fields: bit 7 = run, bit 5 = update permit, bits 9:8 = source. It sets the applied bit 10, clears bit 11 and restarts the count at 0. A new unlock clears bit 10.
- R5: Source 0 advances the count every cycle. Any other source value advances it only on cycles where slow_tick is high. With run = 0 the count does not advance.
- R6: Committing with bit 5 = 0 freezes the configuration until reset: later unlock keys are ignored and limit writes have no effect.
- R7: Writing 0x0000A602 and then 0x0000B480 to word 1, with no other write between them, sets the count (word 1) to 0. An intervening write abandons the sequence.
- R8: On an advancing cycle with count >= limit, the count returns to 0, rst_req is high for the following cycle and irq (control bit 14) is set.
- R9: Writing a 1 to control bit 14 clears irq, whatever the lock state.
- R10: When a valid restart completes in the same cycle as a timeout would occur, the restart wins and no reset request is raised.
- R11: With window != 0 and run = 1, a restart completed while count < window raises rst_req and irq. A restart at count >= window does not. Window 0 accepts a restart at any count.
- R12: With no control write, the open period ends after OPEN_CYCLES cycles. Bit 11 then reads 0 and limit writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word index: 0 control, 1 count, 2 limit, 3 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the indexed word, combinational |
| slow_tick | input | 1 | Tick enable of the slow count source |
| rst_req | output | 1 | One-cycle reset request per timeout or violation |
| irq | output | 1 | Sticky timeout flag (control bit 14) |

## Verification
Restart completion and timeout detection can fall in the same clock edge. The bench aligns the second restart word so that it is sampled exactly on the edge where the count has reached the limit. It then judges that the count is zero and that no reset request appears in the following cycle. A window violation also coincides with a restart. This case is provoked right after a commit, and the bench expects the reset pulse and the flag in the same cycle as the cleared count. A behavioural model predicts every output and read word on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        LK_SHUT   = 2'd0,
        LK_OPEN   = 2'd1,
        LK_FROZEN = 2'd2
    } lock_st_t;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } key_st_t;

    typedef enum logic [1:0] {
        RG_CTRL   = 2'd0,
        RG_COUNT  = 2'd1,
        RG_LIMIT  = 2'd2,
        RG_WINDOW = 2'd3
    } reg_sel_t;

    localparam logic [31:0] UNLOCK_A  = 32'h0000_C520;
    localparam logic [31:0] UNLOCK_B  = 32'h0000_D928;
    localparam logic [31:0] REFRESH_A = 32'h0000_A602;
    localparam logic [31:0] REFRESH_B = 32'h0000_B480;

    localparam int B_UPD     = 5;
    localparam int B_RUN     = 7;
    localparam int B_SRC     = 8;
    localparam int B_APPLIED = 10;
    localparam int B_OPEN    = 11;
    localparam int B_FLAG    = 14;

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter logic [31:0] FIRST  = 32'h0,
    parameter logic [31:0] SECOND = 32'h0,
    parameter logic [1:0]  TARGET = 2'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic        hit
);

    key_st_t st_q, st_d;
    logic    to_target;

    assign to_target = wr && (addr == TARGET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KS_IDLE:  if (to_target && (wdata == FIRST)) st_d = KS_ARMED;
            KS_ARMED: if (wr) st_d = KS_IDLE;
            default:  st_d = KS_IDLE;
        endcase
    end

    always_comb begin
        hit = (st_q == KS_ARMED) && to_target && (wdata == SECOND);
    end

endmodule

// File: rtl/wdt_lock_fsm.sv
module wdt_lock_fsm
    import wdt_pkg::*;
#(
    parameter int OPEN_CYCLES = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_hit,
    input  logic ctrl_wr,
    input  logic upd_bit,
    output logic open,
    output logic frozen,
    output logic commit,
    output logic applied
);

    localparam int TW = $clog2(OPEN_CYCLES + 1);
    localparam logic [TW-1:0] T_LAST = TW'(OPEN_CYCLES - 1);

    lock_st_t        st_q, st_d;
    logic [TW-1:0]   tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_SHUT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_SHUT:   if (unlock_hit) st_d = LK_OPEN;
            LK_OPEN: begin
                if (ctrl_wr)              st_d = upd_bit ? LK_SHUT : LK_FROZEN;
                else if (tmr_q == T_LAST) st_d = LK_SHUT;
            end
            LK_FROZEN: st_d = LK_FROZEN;
            default:   st_d = LK_SHUT;
        endcase
    end

    always_comb begin
        open   = (st_q == LK_OPEN);
        frozen = (st_q == LK_FROZEN);
        commit = (st_q == LK_OPEN) && ctrl_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               tmr_q <= '0;
        else if (st_q != LK_OPEN) tmr_q <= '0;
        else                      tmr_q <= tmr_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              applied <= 1'b0;
        else if (commit)                         applied <= 1'b1;
        else if ((st_q == LK_SHUT) && unlock_hit) applied <= 1'b0;
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [1:0]         src_sel,
    input  logic               slow_tick,
    input  logic               refresh_hit,
    input  logic               restart,
    input  logic [COUNT_W-1:0] limit,
    input  logic [COUNT_W-1:0] window,
    output logic [COUNT_W-1:0] count,
    output logic               fire,
    output logic               rst_req
);

    logic               adv;
    logic [COUNT_W-1:0] cnt_d;

    assign adv = run && ((src_sel == 2'd0) || slow_tick);

    always_comb begin
        cnt_d = count;
        fire  = 1'b0;
        if (refresh_hit) begin
            cnt_d = '0;
            fire  = run && (window != '0) && (count < window);
        end else if (restart) begin
            cnt_d = '0;
        end else if (adv) begin
            if (count >= limit) begin
                cnt_d = '0;
                fire  = 1'b1;
            end else begin
                cnt_d = count + COUNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            rst_req <= 1'b0;
        end else begin
            count   <= cnt_d;
            rst_req <= fire;
        end
    end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int COUNT_W     = 16,
    parameter int OPEN_CYCLES = 255,
    parameter int LIMIT_RST   = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        slow_tick,
    output logic        rst_req,
    output logic        irq
);

    localparam int NKEYS = 2;
    localparam logic [NKEYS-1:0][31:0] KEY_FIRST  = {REFRESH_A, UNLOCK_A};
    localparam logic [NKEYS-1:0][31:0] KEY_SECOND = {REFRESH_B, UNLOCK_B};

    logic [NKEYS-1:0]   key_hit;
    logic               unlock_hit, refresh_hit;
    logic               lk_open, lk_frozen, lk_commit, lk_applied;
    logic               ctrl_wr, fire;
    logic               run_q, upd_q, flag_q;
    logic [1:0]         src_q;
    logic [COUNT_W-1:0] lim_q, win_q, count;

    assign ctrl_wr = bus_wr && (bus_addr == RG_CTRL);

    for (genvar g = 0; g < NKEYS; g++) begin : g_key
        wdt_key_seq #(
            .FIRST  (KEY_FIRST[g]),
            .SECOND (KEY_SECOND[g]),
            .TARGET (RG_COUNT)
        ) u_key (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (bus_wr),
            .addr  (bus_addr),
            .wdata (bus_wdata),
            .hit   (key_hit[g])
        );
    end

    assign unlock_hit  = key_hit[0];
    assign refresh_hit = key_hit[1];

    wdt_lock_fsm #(.OPEN_CYCLES(OPEN_CYCLES)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlock_hit (unlock_hit),
        .ctrl_wr    (ctrl_wr),
        .upd_bit    (bus_wdata[B_UPD]),
        .open       (lk_open),
        .frozen     (lk_frozen),
        .commit     (lk_commit),
        .applied    (lk_applied)
    );

    wdt_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_q),
        .src_sel     (src_q),
        .slow_tick   (slow_tick),
        .refresh_hit (refresh_hit),
        .restart     (lk_commit),
        .limit       (lim_q),
        .window      (win_q),
        .count       (count),
        .fire        (fire),
        .rst_req     (rst_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            upd_q <= 1'b1;
            src_q <= 2'd0;
            lim_q <= COUNT_W'(LIMIT_RST);
            win_q <= '0;
        end else begin
            if (lk_commit) begin
                run_q <= bus_wdata[B_RUN];
                upd_q <= bus_wdata[B_UPD];
                src_q <= bus_wdata[B_SRC+1:B_SRC];
            end
            if (lk_open && bus_wr && (bus_addr == RG_LIMIT))  lim_q <= bus_wdata[COUNT_W-1:0];
            if (lk_open && bus_wr && (bus_addr == RG_WINDOW)) win_q <= bus_wdata[COUNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          flag_q <= 1'b0;
        else if (fire)                       flag_q <= 1'b1;
        else if (ctrl_wr && bus_wdata[B_FLAG]) flag_q <= 1'b0;
    end

    assign irq = flag_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            RG_CTRL: begin
                bus_rdata[B_FLAG]          = flag_q;
                bus_rdata[B_OPEN]          = lk_open;
                bus_rdata[B_APPLIED]       = lk_applied;
                bus_rdata[B_SRC+1:B_SRC]   = src_q;
                bus_rdata[B_RUN]           = run_q;
                bus_rdata[B_UPD]           = upd_q;
            end
            RG_COUNT:  bus_rdata[COUNT_W-1:0] = count;
            RG_LIMIT:  bus_rdata[COUNT_W-1:0] = lim_q;
            RG_WINDOW: bus_rdata[COUNT_W-1:0] = win_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [1:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               rst_req,
    input logic               irq,
    input logic               unlocked,
    input logic               applied,
    input logic               frozen,
    input logic               refresh_hit,
    input logic [COUNT_W-1:0] count,
    input logic [COUNT_W-1:0] lim_q
);

    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && (bus_addr == 2'd1) && (bus_wdata == UNLOCK_B)));

    p_limit_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 2'd2) && !unlocked) |=> $stable(lim_q));

    p_commit_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(applied) |-> $past(bus_wr && (bus_addr == 2'd0)));

    p_frozen_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> frozen);

    p_frozen_shut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !unlocked);

    p_refresh_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_hit |=> (count == '0));

    p_req_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> irq);

    p_clear_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr && (bus_addr == 2'd0) && bus_wdata[B_FLAG]));

endmodule

bind wdt_keyed wdt_keyed_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .rst_req     (rst_req),
    .irq         (irq),
    .unlocked    (lk_open),
    .applied     (lk_applied),
    .frozen      (lk_frozen),
    .refresh_hit (refresh_hit),
    .count       (count),
    .lim_q       (lim_q)
);

// File: tb/wdt_keyed_test.sv
`timescale 1ns/100ps
module wdt_keyed_test;

    localparam int OPEN_CYC = 16;
    localparam int LIM_RST  = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        slow_tick = 1'b0;
    logic        rst_req, irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit started = 1'b0;
    bit done    = 1'b0;
    bit tick_on = 1'b0;
    int tick_div = 0;

    // reference model state
    int m_lk = 0, m_tmr = 0, m_uarm = 0, m_rarm = 0;
    int m_flg = 0, m_app = 0, m_src = 0, m_run = 0, m_upd = 1;
    int m_cnt = 0, m_lim = LIM_RST, m_win = 0, m_rst = 0;
    // model temporaries
    bit t_wr, t_uhit, t_rhit, t_commit, t_fire;
    int t_a, t_cn;
    logic [31:0] t_d;

    always #2.5 clk = ~clk;

    wdt_keyed #(.COUNT_W(16), .OPEN_CYCLES(OPEN_CYC), .LIMIT_RST(LIM_RST)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slow_tick(slow_tick),
        .rst_req(rst_req), .irq(irq)
    );

    always @(posedge clk) begin
        #2;
        tick_div  = (tick_div + 1) % 4;
        slow_tick = tick_on && (tick_div == 0);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lk = 0; m_tmr = 0; m_uarm = 0; m_rarm = 0; m_flg = 0; m_app = 0;
            m_src = 0; m_run = 0; m_upd = 1; m_cnt = 0; m_lim = LIM_RST; m_win = 0; m_rst = 0;
        end else begin
            t_wr = bus_wr; t_a = int'(bus_addr); t_d = bus_wdata;
            t_uhit   = (m_uarm != 0) && t_wr && t_a == 1 && t_d == 32'h0000D928;
            t_rhit   = (m_rarm != 0) && t_wr && t_a == 1 && t_d == 32'h0000B480;
            t_commit = (m_lk == 1) && t_wr && t_a == 0;
            if (t_wr) begin
                m_uarm = (m_uarm == 0 && t_a == 1 && t_d == 32'h0000C520) ? 1 : 0;
                m_rarm = (m_rarm == 0 && t_a == 1 && t_d == 32'h0000A602) ? 1 : 0;
            end
            t_fire = 1'b0; t_cn = m_cnt;
            if (t_rhit) begin
                t_fire = (m_run != 0) && m_win != 0 && m_cnt < m_win;
                t_cn = 0;
            end else if (t_commit) begin
                t_cn = 0;
            end else if (m_run != 0 && (m_src == 0 || slow_tick)) begin
                if (m_cnt >= m_lim) begin t_fire = 1'b1; t_cn = 0; end
                else t_cn = m_cnt + 1;
            end
            m_rst = t_fire ? 1 : 0;
            if (t_fire) m_flg = 1;
            else if (t_wr && t_a == 0 && t_d[14]) m_flg = 0;
            if (m_lk == 1 && t_wr && t_a == 2) m_lim = int'(t_d[15:0]);
            if (m_lk == 1 && t_wr && t_a == 3) m_win = int'(t_d[15:0]);
            case (m_lk)
                0: if (t_uhit) begin m_lk = 1; m_tmr = 0; m_app = 0; end
                1: begin
                    if (t_commit) begin
                        m_run = int'(t_d[7]); m_upd = int'(t_d[5]); m_src = int'(t_d[9:8]);
                        m_app = 1; m_lk = t_d[5] ? 0 : 2;
                    end else if (m_tmr == OPEN_CYC - 1) m_lk = 0;
                    else m_tmr = m_tmr + 1;
                end
                default: ;
            endcase
            m_cnt = t_cn;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        logic [31:0] v;
        v = 32'h0;
        case (a)
            2'd0: begin
                v[14] = (m_flg != 0); v[11] = (m_lk == 1); v[10] = (m_app != 0);
                v[9:8] = 2'(m_src); v[7] = (m_run != 0); v[5] = (m_upd != 0);
            end
            2'd1: v = 32'(m_cnt);
            2'd2: v = 32'(m_lim);
            default: v = 32'(m_win);
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && started && !done) begin
            case (bus_addr)
                2'd0: chk("R4 ctrl word vs model", bus_rdata, exp_rd(bus_addr));
                2'd1: chk("R7 count vs model", bus_rdata, exp_rd(bus_addr));
                2'd2: chk("R3 limit vs model", bus_rdata, exp_rd(bus_addr));
                default: chk("R11 window vs model", bus_rdata, exp_rd(bus_addr));
            endcase
            chk("R8 rst_req vs model", 32'(rst_req), 32'(m_rst));
            chk("R9 irq vs model", 32'(irq), 32'(m_flg));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic look(input logic [1:0] a, input logic [31:0] mask, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata & mask, exp);
    endtask

    task automatic unlock();
        wr(2'd1, 32'h0000C520);
        wr(2'd1, 32'h0000D928);
    endtask

    task automatic refresh();
        wr(2'd1, 32'h0000A602);
        wr(2'd1, 32'h0000B480);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        started = 1'b1;

        // R1 reset state
        look(2'd0, 32'hFFFF_FFFF, 32'h20, "R1 ctrl after reset");
        look(2'd1, 32'hFFFF_FFFF, 32'h0, "R1 count after reset");
        look(2'd2, 32'hFFFF_FFFF, 32'(LIM_RST), "R1 limit after reset");
        look(2'd3, 32'hFFFF_FFFF, 32'h0, "R1 window after reset");
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 rst_req after reset", 32'(rst_req), 32'h0);

        // R2 broken key, R3 locked limit write
        wr(2'd1, 32'h0000C520);
        wr(2'd1, 32'h00001234);
        wr(2'd1, 32'h0000D928);
        look(2'd0, 32'hFFFF_FFFF, 32'h20, "R2 interrupted key stays locked");
        wr(2'd2, 32'd5);
        look(2'd2, 32'hFFFF_FFFF, 32'(LIM_RST), "R3 limit ignored while locked");

        // R2 proper unlock, R4 commit
        unlock();
        look(2'd0, 32'hFFFF_FFFF, 32'h820, "R2 unlock flag");
        wr(2'd2, 32'd20);
        wr(2'd3, 32'd0);
        wr(2'd0, 32'h0000_00A0);
        look(2'd0, 32'hFFFF_FFFF, 32'h4A0, "R4 committed ctrl");
        look(2'd2, 32'hFFFF_FFFF, 32'd20, "R4 limit loaded while open");
        idle(5);
        look(2'd1, 32'hFFFF_FFFF, 32'd5, "R5 bus-clock count");

        // R8 timeout
        for (int i = 0; i < 60 && !rst_req; i++) idle(1);
        chk("R8 rst_req raised", 32'(rst_req), 32'h1);
        chk("R8 irq set", 32'(irq), 32'h1);
        look(2'd0, 32'hFFFF_FFFF, 32'h44A0, "R8 flag bit in ctrl");
        idle(1);
        chk("R8 rst_req one cycle", 32'(rst_req), 32'h0);

        // R9 clear while locked, R3 other fields ignored
        wr(2'd0, 32'h0000_4000);
        chk("R9 irq cleared", 32'(irq), 32'h0);
        look(2'd0, 32'hFFFF_FFFF, 32'h4A0, "R3 locked ctrl write keeps fields");

        // R7 refresh and abandoned refresh
        refresh();
        look(2'd1, 32'hFFFF_FFFF, 32'd0, "R7 refresh zeroes count");
        wr(2'd1, 32'h0000A602);
        wr(2'd1, 32'h00001234);
        wr(2'd1, 32'h0000B480);
        look(2'd1, 32'hFFFF_FFFF, 32'd3, "R7 interrupted refresh ignored");

        // R10 refresh on the timeout edge
        refresh();
        idle(19);
        refresh();
        chk("R10 no reset on coinciding refresh", 32'(rst_req), 32'h0);
        look(2'd1, 32'hFFFF_FFFF, 32'd0, "R10 count zero after coinciding refresh");
        idle(1);
        chk("R10 still no reset", 32'(rst_req), 32'h0);

        // R5 slow source
        unlock();
        wr(2'd0, 32'h0000_01A0);
        look(2'd0, 32'hFFFF_FFFF, 32'h5A0, "R5 slow source committed");
        idle(10);
        look(2'd1, 32'hFFFF_FFFF, 32'd0, "R5 no ticks no count");
        tick_on = 1'b1;
        idle(12);
        tick_on = 1'b0;
        look(2'd1, 32'hFFFF_FFFF, 32'd3, "R5 count follows slow ticks");

        // R11 window
        unlock();
        wr(2'd2, 32'd50);
        wr(2'd3, 32'd10);
        wr(2'd0, 32'h0000_00A0);
        wr(2'd0, 32'h0000_4000);
        refresh();
        chk("R11 early refresh raises rst_req", 32'(rst_req), 32'h1);
        chk("R11 early refresh sets irq", 32'(irq), 32'h1);
        idle(15);
        refresh();
        chk("R11 late refresh accepted", 32'(rst_req), 32'h0);
        look(2'd1, 32'hFFFF_FFFF, 32'd0, "R11 late refresh zeroes count");

        // R12 open period expiry, R4 applied cleared by unlock
        unlock();
        look(2'd0, 32'h0000_0C00, 32'h800, "R4 unlock clears applied");
        idle(OPEN_CYC + 2);
        look(2'd0, 32'h0000_0800, 32'h0, "R12 open period expired");
        wr(2'd2, 32'd7);
        look(2'd2, 32'hFFFF_FFFF, 32'd50, "R12 limit ignored after expiry");

        // R6 freeze
        unlock();
        wr(2'd0, 32'h0000_0080);
        look(2'd0, 32'h0000_0CA0, 32'h480, "R6 frozen config");
        unlock();
        look(2'd0, 32'h0000_0800, 32'h0, "R6 unlock ignored when frozen");
        wr(2'd2, 32'd9);
        look(2'd2, 32'hFFFF_FFFF, 32'd50, "R6 limit fixed when frozen");

        idle(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule